// File: doc/BRIEF.md
# Two-Port Address Collision Arbiter

This block sits between the two access ports of a shared two-port memory and the memory's write strobes. Every cycle it compares the two ports: when both are selected and point at the same word, it declares a collision, picks one port as the owner and pulls the active-low busy flag of the other port. A port that sees its busy flag low should stall. Any write it tries during that time is removed from its internal write strobe, so the array is never written by the losing side. Reads on a busy port are not blocked, but the data they return may not be valid.

The owner is the port whose selected address was already in place in the previous cycle when the other port arrived. The choice ignores whether either access is a read or a write. When both ports arrive in the same cycle, port A wins and port B gets busy. After an owner is chosen it is held for as long as the collision lasts. Busy is released in the same cycle the collision ends, and the held-off write goes through then.

A parameter selects the role. In master mode the block makes its own decision and drives it on its busy outputs. In slave mode there is no arbitration logic: both busy outputs stay high, and the busy inputs act only as per-port write inhibits. This lets several devices that form one wide word follow the decision of a single master. In master mode the busy inputs also inhibit writes, so a port can be locked by tying its input low.

The decision is made by a three-state machine:
- ARB_IDLE: no owner is held.
- ARB_A_OWNS: A owns the word and B is busy.
- ARB_B_OWNS: B owns the word and A is busy.

Transitions:
- From ARB_IDLE, a collision moves to ARB_B_OWNS if only B was already settled on its address. Any other collision moves to ARB_A_OWNS.
- From either owner state, the machine returns to ARB_IDLE in the first cycle without a collision.
- Otherwise the machine stays in its owner state.

Top module: `dp_collide_arb`

## Requirements
- R1: In master mode, busy_a_n and busy_b_n are both 1 whenever ce_a, ce_b and addr_a==addr_b are not all true.
- R2: Arbitration ignores we_a and we_b: for the same enables and addresses, the busy outputs are the same whether each access is a read or a write.
- R3: On a collision, the port that was enabled at the same address in the previous cycle (and whose partner was not) keeps its busy at 1, and the newly arriving port sees its busy at 0 in the cycle it arrives.
- R4: busy_a_n and busy_b_n are never 0 at the same time.
- R5: When neither port, or both ports, were settled on the address in the previous cycle, a collision gives busy_b_n=0 and busy_a_n=1.
- R6: wr_a = ce_a & we_a & busy_a_n & busy_in_a_n in the same cycle, and likewise for port B. A port whose busy is 0 never has its write strobe at 1.
- R7: In slave mode (IS_MASTER=0), both busy outputs stay at 1. A busy input at 0 blocks all writes on its port, and a busy input at 1 leaves that port's writes untouched.
- R8: In the first cycle where the addresses differ or either enable is 0, both busy outputs return to 1, and a pending write on the former loser reaches its strobe.
- R9: While a collision continues without a break, the busy side does not change, even once both ports count as settled.
- R10: After reset the machine holds no owner, so with no collision both busy outputs are 1 and both write strobes follow their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a | input | 1 | Port A select, active high |
| we_a | input | 1 | Port A write request, active high |
| addr_a | input | ADDR_W | Port A word address |
| busy_in_a_n | input | 1 | Port A external write inhibit, active low |
| ce_b | input | 1 | Port B select, active high |
| we_b | input | 1 | Port B write request, active high |
| addr_b | input | ADDR_W | Port B word address |
| busy_in_b_n | input | 1 | Port B external write inhibit, active low |
| busy_a_n | output | 1 | Port A busy flag, active low |
| busy_b_n | output | 1 | Port B busy flag, active low |
| wr_a | output | 1 | Gated write strobe to the array for port A |
| wr_b | output | 1 | Gated write strobe to the array for port B |

## Verification
A sweep from a quiet cycle covers every enable, write and address pair on a small address space. A design that lets the write bit steer the decision, flags mismatched addresses, or breaks a tie toward B fails there. Directed sequences present one port a cycle ahead of the other in both orders: a fixed-priority arbiter gives busy to the wrong side in one of them. The collision is then held on, so a design that re-decides every cycle would move busy to the other port once both count as settled. The collision is ended both by a deselect and by an address change, where a late release would keep the pending write off its strobe. The slave instance is driven with every pair of inhibit inputs to show that it only blocks writes and never raises busy.

// File: rtl/dparb_pkg.sv
package dparb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_A_OWNS = 2'd1,
        ARB_B_OWNS = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dparb_port_track.sv
// Remembers whether a port was selected at the same address one cycle ago.
module dparb_port_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              ce_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            ce_q   <= ce;
            addr_q <= addr;
        end
    end

    assign settled = ce && ce_q && (addr == addr_q);
endmodule

// File: rtl/dparb_fsm.sv
// Owner selection: decides on a fresh collision, holds the owner while it lasts.
module dparb_fsm
    import dparb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic collide,
    input  logic a_settled,
    input  logic b_settled,
    output logic a_loses,
    output logic b_loses
);
    arb_state_t state_q, state_d;
    logic       b_first;

    assign b_first = b_settled && !a_settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:   if (collide) state_d = b_first ? ARB_B_OWNS : ARB_A_OWNS;
            ARB_A_OWNS: if (!collide) state_d = ARB_IDLE;
            ARB_B_OWNS: if (!collide) state_d = ARB_IDLE;
            default:    state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        a_loses = 1'b0;
        b_loses = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                a_loses = collide && b_first;
                b_loses = collide && !b_first;
            end
            ARB_A_OWNS: b_loses = collide;
            ARB_B_OWNS: a_loses = collide;
            default: begin
                a_loses = 1'b0;
                b_loses = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dparb_wr_gate.sv
module dparb_wr_gate (
    input  logic ce,
    input  logic we,
    input  logic busy_n,
    input  logic inhibit_n,
    output logic wr
);
    assign wr = ce && we && busy_n && inhibit_n;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb #(
    parameter int ADDR_W    = 11,
    parameter bit IS_MASTER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              busy_in_a_n,
    input  logic              ce_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              busy_in_b_n,
    output logic              busy_a_n,
    output logic              busy_b_n,
    output logic              wr_a,
    output logic              wr_b
);
    generate
        if (IS_MASTER) begin : g_master
            logic collide, a_settled, b_settled, a_loses, b_loses;

            assign collide = ce_a && ce_b && (addr_a == addr_b);

            dparb_port_track #(.ADDR_W(ADDR_W)) u_trk_a (
                .clk(clk), .rst_n(rst_n), .ce(ce_a), .addr(addr_a), .settled(a_settled));
            dparb_port_track #(.ADDR_W(ADDR_W)) u_trk_b (
                .clk(clk), .rst_n(rst_n), .ce(ce_b), .addr(addr_b), .settled(b_settled));

            dparb_fsm u_fsm (
                .clk(clk), .rst_n(rst_n), .collide(collide),
                .a_settled(a_settled), .b_settled(b_settled),
                .a_loses(a_loses), .b_loses(b_loses));

            assign busy_a_n = !a_loses;
            assign busy_b_n = !b_loses;
        end else begin : g_slave
            assign busy_a_n = 1'b1;
            assign busy_b_n = 1'b1;
        end
    endgenerate

    dparb_wr_gate u_gate_a (
        .ce(ce_a), .we(we_a), .busy_n(busy_a_n), .inhibit_n(busy_in_a_n), .wr(wr_a));
    dparb_wr_gate u_gate_b (
        .ce(ce_b), .we(we_b), .busy_n(busy_b_n), .inhibit_n(busy_in_b_n), .wr(wr_b));
endmodule

// File: rtl/dp_collide_arb_chk.sv
module dp_collide_arb_chk #(
    parameter int ADDR_W    = 11,
    parameter bit IS_MASTER = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_a,
    input logic              we_a,
    input logic [ADDR_W-1:0] addr_a,
    input logic              busy_in_a_n,
    input logic              ce_b,
    input logic              we_b,
    input logic [ADDR_W-1:0] addr_b,
    input logic              busy_in_b_n,
    input logic              busy_a_n,
    input logic              busy_b_n,
    input logic              wr_a,
    input logic              wr_b
);
    logic coll;
    logic armed;

    assign coll = ce_a && ce_b && (addr_a == addr_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r4_never_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_a_n && !busy_b_n));

    a_r1_quiet_without_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !coll |-> (busy_a_n && busy_b_n));

    a_r6_no_write_a_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_a_n || !busy_in_a_n) |-> !wr_a);

    a_r6_no_write_b_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_b_n || !busy_in_b_n) |-> !wr_b);

    a_r9_owner_b_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && coll && $past(coll) && ($past(busy_b_n) == 1'b0)) |-> !busy_b_n);

    a_r9_owner_a_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && coll && $past(coll) && ($past(busy_a_n) == 1'b0)) |-> !busy_a_n);

    a_r7_slave_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_MASTER == 1'b0) |-> (busy_a_n && busy_b_n));

    a_r5_fresh_tie_b_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_MASTER && armed && coll && !$past(ce_a) && !$past(ce_b)) |-> (!busy_b_n && busy_a_n));
endmodule

bind dp_collide_arb dp_collide_arb_chk #(.ADDR_W(ADDR_W), .IS_MASTER(IS_MASTER)) u_chk (.*);

// File: tb/dp_collide_arb_tb.sv
`timescale 1ns/100ps
module dp_collide_arb_tb;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_a = 0, we_a = 0, ce_b = 0, we_b = 0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic m_in_a = 1, m_in_b = 1, s_in_a = 1, s_in_b = 1;
    logic m_busy_a, m_busy_b, m_wr_a, m_wr_b;
    logic s_busy_a, s_busy_b, s_wr_a, s_wr_b;
    int   n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    dp_collide_arb #(.ADDR_W(AW), .IS_MASTER(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ce_a(ce_a), .we_a(we_a), .addr_a(addr_a), .busy_in_a_n(m_in_a),
        .ce_b(ce_b), .we_b(we_b), .addr_b(addr_b), .busy_in_b_n(m_in_b),
        .busy_a_n(m_busy_a), .busy_b_n(m_busy_b), .wr_a(m_wr_a), .wr_b(m_wr_b));

    dp_collide_arb #(.ADDR_W(AW), .IS_MASTER(1'b0)) u_slv (
        .clk(clk), .rst_n(rst_n),
        .ce_a(ce_a), .we_a(we_a), .addr_a(addr_a), .busy_in_a_n(s_in_a),
        .ce_b(ce_b), .we_b(we_b), .addr_b(addr_b), .busy_in_b_n(s_in_b),
        .busy_a_n(s_busy_a), .busy_b_n(s_busy_b), .wr_a(s_wr_a), .wr_b(s_wr_b));

    // vector order: {busy_a_n, busy_b_n, wr_a, wr_b}
    task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic next_cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic ca, input logic wa, input logic [AW-1:0] aa,
                         input logic cb, input logic wb, input logic [AW-1:0] ab);
        ce_a = ca; we_a = wa; addr_a = aa;
        ce_b = cb; we_b = wb; addr_b = ab;
        #1;
    endtask

    task automatic quiet();
        next_cyc();
        drive(0, 0, '0, 0, 0, '0);
        next_cyc();
    endtask

    function automatic logic [3:0] mvec();
        return {m_busy_a, m_busy_b, m_wr_a, m_wr_b};
    endfunction
    function automatic logic [3:0] svec();
        return {s_busy_a, s_busy_b, s_wr_a, s_wr_b};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        #1;
        cmp("R10 reset master", mvec(), 4'b1100);
        cmp("R10 reset slave", svec(), 4'b1100);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        next_cyc();
        drive(1, 1, 3'd1, 1, 1, 3'd2);
        cmp("R10 after reset", mvec(), 4'b1111);

        // Sweep from a quiet cycle: R1 R2 R5 R6, slave pass-through R7
        for (int v = 0; v < 1024; v++) begin
            logic ca, cb, wa, wb, coll;
            logic [AW-1:0] aa, ab;
            {ca, cb, wa, wb} = v[9:6];
            aa = v[5:3];
            ab = v[2:0];
            quiet();
            drive(ca, wa, aa, cb, wb, ab);
            coll = ca && cb && (aa == ab);
            cmp(coll ? "R5 R2 tie sweep" : "R1 R6 no-collision sweep",
                mvec(), {1'b1, !coll, ca && wa, cb && wb && !coll});
            cmp("R7 slave sweep", svec(), {1'b1, 1'b1, ca && wa, cb && wb});
        end

        // R3: A settled first, B arrives
        quiet();
        drive(1, 1, 3'd5, 0, 0, 3'd0);
        cmp("R3 A alone", mvec(), 4'b1110);
        next_cyc();
        drive(1, 1, 3'd5, 1, 1, 3'd5);
        cmp("R3 B arrives late", mvec(), 4'b1010);
        next_cyc();
        cmp("R9 A keeps word", mvec(), 4'b1010);
        next_cyc();
        drive(0, 0, 3'd5, 1, 1, 3'd5);
        cmp("R8 release on deselect", mvec(), 4'b1101);

        // R3: B settled first, A arrives with a read
        quiet();
        drive(0, 0, 3'd2, 1, 1, 3'd2);
        next_cyc();
        drive(1, 1, 3'd2, 1, 0, 3'd2);
        cmp("R3 A arrives late", mvec(), 4'b0100);
        next_cyc();
        cmp("R9 B keeps word (no tie flip)", mvec(), 4'b0100);
        next_cyc();
        cmp("R9 B keeps word again", mvec(), 4'b0100);
        drive(1, 1, 3'd2, 1, 0, 3'd3);
        cmp("R8 release on address change", mvec(), 4'b1110);

        // R3: both present at different words, A moves onto B's word
        quiet();
        drive(1, 1, 3'd4, 1, 1, 3'd6);
        next_cyc();
        drive(1, 1, 3'd6, 1, 1, 3'd6);
        cmp("R3 A moves onto settled B", mvec(), 4'b0101);

        // R5: both settled at different words then both move together
        quiet();
        drive(1, 0, 3'd1, 1, 0, 3'd7);
        next_cyc();
        drive(1, 1, 3'd0, 1, 1, 3'd0);
        cmp("R5 simultaneous move", mvec(), 4'b1010);

        // R7: slave inhibit inputs, all pairs, both writing at distinct words
        quiet();
        for (int k = 0; k < 4; k++) begin
            s_in_a = k[1];
            s_in_b = k[0];
            drive(1, 1, 3'd1, 1, 1, 3'd2);
            cmp("R7 slave inhibit", svec(), {2'b11, k[1], k[0]});
            drive(1, 1, 3'd3, 1, 1, 3'd3);
            cmp("R7 slave ignores collision", svec(), {2'b11, k[1], k[0]});
        end
        s_in_a = 1; s_in_b = 1;

        // R6: master external inhibit blocks writes without raising busy
        quiet();
        m_in_a = 0;
        drive(1, 1, 3'd1, 1, 1, 3'd2);
        cmp("R6 master inhibit A", mvec(), 4'b1101);
        m_in_a = 1;
        m_in_b = 0;
        drive(1, 1, 3'd1, 1, 1, 3'd2);
        cmp("R6 master inhibit B", mvec(), 4'b1110);
        m_in_b = 1;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule